// File: doc/BRIEF.md
# Dual-Modulus Prescaler

This block divides a fast input clock by P or by P+1. P is one of 8, 16, 32 or 64, chosen by a 2-bit mode field. A swallow-control input picks between P and P+1 once per output period. The block emits one registered output pulse per division period, which is slow enough to drive the downstream main and swallow counters of a feedback divider.

Every modulus comes from one synchronous divide-by-4/5 core. The core is followed by one to four divide-by-2 extension stages. The core counts five input cycles only once per period: in its last core cycle, when the swallow request latched for that period is set and every active extension stage is at its terminal value. In all other core cycles it counts four.

The swallow request and the mode are both sampled on the clock edge that ends a period, and they govern the period that follows. Only in the first period after reset is the live mode used. The swallow request is taken as low in that first period, so it already has the length P.

Top module: `dmod_prescaler`

## Requirements
- R1: While rst_ni is low, div_o is low. The first div_o pulse after reset is released comes exactly P input clock edges after release, where P is set by mode_i. This holds whatever the level of swallow_i.
- R2: Mode encoding is mode_i = 2'b00 for P=8, 2'b01 for P=16, 2'b10 for P=32 and 2'b11 for P=64. A period whose sampled swallow request is 0 lasts P cycles, measured between div_o rising edges.
- R3: If swallow_i is 1 on the edge that raises div_o, the period that starts there lasts P+1 cycles.
- R4: swallow_i and mode_i are sampled only on the edge that ends a period. Changes to them at any other time leave the period lengths unchanged.
- R5: div_o is high for exactly one input cycle per period, and it is driven from a register.
- R6: A new mode_i value, applied at a period boundary, sets the length of the next period.
- R7: The interval between div_o pulses is never shorter than 8 input cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Modulus select: 00=8/9, 01=16/17, 10=32/33, 11=64/65 |
| swallow_i | input | 1 | Modulus control; high requests P+1 for the next period |
| div_o | output | 1 | One-cycle registered pulse per division period |

## Verification
The assertions assume the following about the inputs:
- mode_i does not change during the first period after reset, because the live mode sets that period.
- swallow_i and mode_i are settled at the edge that ends each period.

The stimulus keeps to these assumptions. It alters mode only after a div_o pulse has been seen. It scrambles both inputs with random values only in the early part of a period, and it restores the intended values at least two cycles before the expected boundary. Swallow is held high through reset and through the first period, to show that it is ignored there.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  localparam int unsigned CORE_LOW = 4;
  localparam int unsigned EXT_MAX  = 4;
  localparam int unsigned MODE_W   = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_8  = 2'b00,
    MODE_16 = 2'b01,
    MODE_32 = 2'b10,
    MODE_64 = 2'b11
  } mode_e;

  // active extension stages = mode + 1, packed from bit 0
  function automatic logic [EXT_MAX-1:0] ext_mask(input mode_e m);
    logic [EXT_MAX-1:0] r;
    r = '0;
    for (int i = 0; i < EXT_MAX; i++)
      if (i <= int'(m)) r[i] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/dmp_core45.sv
module dmp_core45 #(
  parameter int unsigned LOW   = dmp_pkg::CORE_LOW,
  localparam int unsigned CNT_W = $clog2(LOW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             extend_i,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last   = extend_i ? CNT_W'(LOW) : CNT_W'(LOW - 1);
  assign wrap_o = (cnt_q == last);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dmp_ext_chain.sv
module dmp_ext_chain #(
  parameter int unsigned N_STG = dmp_pkg::EXT_MAX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [N_STG-1:0] mask_i,
  output logic             term_o
);
  logic [N_STG-1:0] stg_q;
  logic [N_STG-1:0] tog;
  logic [N_STG:0]   carry;

  assign carry[0] = step_i;

  for (genvar i = 0; i < N_STG; i++) begin : g_stg
    // divide-by-2 stage, enabled only when selected by the mode
    assign tog[i]     = carry[i] & mask_i[i];
    assign carry[i+1] = carry[i] & stg_q[i];
  end

  assign term_o = ((stg_q & mask_i) == mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_q ^ tog;
  end
endmodule

// File: rtl/dmp_mod_ctrl.sv
module dmp_mod_ctrl
  import dmp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bound_i,
  input  logic  swallow_i,
  input  mode_e mode_i,
  output logic  mc_o,
  output mode_e mode_o
);
  logic  first_q;
  logic  mc_q;
  mode_e cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      mc_q    <= 1'b0;
      cfg_q   <= MODE_8;
    end else if (bound_i) begin
      first_q <= 1'b0;
      mc_q    <= swallow_i;
      cfg_q   <= mode_i;
    end
  end

  // live mode only until the first boundary
  assign mode_o = first_q ? mode_i : cfg_q;
  assign mc_o   = mc_q;
endmodule

// File: rtl/dmod_prescaler.sv
module dmod_prescaler
  import dmp_pkg::*;
#(
  parameter int unsigned LOW   = CORE_LOW,
  parameter int unsigned N_STG = EXT_MAX,
  localparam int unsigned CNT_W = $clog2(LOW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              swallow_i,
  output logic              div_o
);
  logic             core_wrap;
  logic [CNT_W-1:0] core_cnt;
  logic             ext_term;
  logic             period_end;
  logic             mc;
  mode_e            mode_eff;
  logic [N_STG-1:0] mask;
  logic             div_q;

  assign mask       = N_STG'(ext_mask(mode_eff));
  assign period_end = core_wrap & ext_term;

  dmp_mod_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bound_i   (period_end),
    .swallow_i (swallow_i),
    .mode_i    (mode_e'(mode_i)),
    .mc_o      (mc),
    .mode_o    (mode_eff)
  );

  dmp_core45 #(.LOW(LOW)) i_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .extend_i (mc & ext_term),
    .wrap_o   (core_wrap),
    .cnt_o    (core_cnt)
  );

  dmp_ext_chain #(.N_STG(N_STG)) i_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (core_wrap),
    .mask_i (mask),
    .term_o (ext_term)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= period_end;
  end

  assign div_o = div_q;
endmodule

// File: rtl/dmp_checker.sv
module dmp_checker #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             div_o,
  input logic             swallow_i,
  input logic             period_end,
  input logic             mc,
  input logic [CNT_W-1:0] core_cnt
);
  logic [7:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gap_q <= '0;
    else if (div_o)         gap_q <= '0;
    else if (gap_q != 8'hff) gap_q <= gap_q + 1'b1;
  end

  p_reset_low_r1: assert property (@(posedge clk_i) !rst_ni |-> !div_o);

  p_pulse_follows_end_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end |=> div_o);

  p_single_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);

  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end |=> (mc == $past(swallow_i)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end |=> $stable(mc));

  p_core_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_cnt <= CNT_W'(4));

  p_min_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |-> (gap_q >= 8'd7));
endmodule

bind dmod_prescaler dmp_checker #(.CNT_W(CNT_W)) i_dmp_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .div_o      (div_o),
  .swallow_i  (swallow_i),
  .period_end (period_end),
  .mc         (mc),
  .core_cnt   (core_cnt)
);

// File: tb/test_dmod_prescaler.sv
module test_dmod_prescaler;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       swallow;
  logic       div;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    cyc_in;
  int    exp_len;
  string tag;
  logic [1:0] nxt_mode;
  logic       nxt_sw;
  bit         first_per;
  bit         pulse_chk;

  always #4 clk = ~clk;

  dmod_prescaler i_dmod_prescaler (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .mode_i    (mode),
    .swallow_i (swallow),
    .div_o     (div)
  );

  function automatic int p_of(input logic [1:0] m);
    return 8 << m;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n   = 1'b0;
    mode    = m;
    swallow = 1'b1;  // ignored in first period (R1)
    repeat (3) @(negedge clk);
    chk(div == 1'b0, "R1 reset", int'(div), 0);
    rst_n     = 1'b1;
    cyc_in    = 0;
    exp_len   = p_of(m);
    tag       = "R1 first period";
    nxt_mode  = m;
    nxt_sw    = 1'b1;
    first_per = 1'b1;
    pulse_chk = 1'b0;
  endtask

  task automatic run(input int n, input bit glitch, input bit vary_mode);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      cyc_in++;
      if (div) begin
        chk(cyc_in == exp_len, tag, cyc_in, exp_len);
        chk(cyc_in >= 8, "R7 min interval", cyc_in, 8);
        exp_len = p_of(mode) + int'(swallow);
        if (first_per)       tag = swallow ? "R3 after reset" : "R2 after reset";
        else if (glitch)     tag = "R4 mid-period changes";
        else if (vary_mode)  tag = swallow ? "R6/R3 mode change" : "R6 mode change";
        else                 tag = swallow ? "R3 swallow" : "R2 base modulus";
        first_per = 1'b0;
        nxt_mode  = vary_mode ? 2'($urandom_range(0, 3)) : mode;
        nxt_sw    = 1'($urandom_range(0, 1));
        cyc_in    = 0;
        pulse_chk = 1'b1;
        k++;
      end else begin
        if (pulse_chk) begin
          chk(div == 1'b0, "R5 pulse width", int'(div), 0);
          pulse_chk = 1'b0;
        end
        if (glitch && !first_per && cyc_in < exp_len - 2) begin
          swallow = 1'($urandom_range(0, 1));
          mode    = 2'($urandom_range(0, 3));
        end else begin
          swallow = nxt_sw;
          mode    = first_per ? mode : nxt_mode;
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n   = 1'b0;
    mode    = 2'b00;
    swallow = 1'b0;

    // directed: each mode after reset, base and swallow
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      run(1, 1'b0, 1'b0);
      nxt_sw = 1'b0;
      swallow = 1'b0;
      run(3, 1'b0, 1'b0);
    end

    do_reset(2'b11);
    run(40, 1'b0, 1'b0);   // R2/R3 at P=64
    do_reset(2'b00);
    run(150, 1'b0, 1'b1);  // R6 random modes
    run(150, 1'b1, 1'b1);  // R4 glitches
    do_reset(2'b01);
    run(100, 1'b1, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule